// File: doc/BRIEF.md
# Level-Encoded Dual-Rail Word Link

This block moves a parallel word from a sender to a receiver over a pair of wires per bit, a value wire and a toggle wire. For every new word, each bit changes exactly one of its two wires. If the bit's value is new, the value wire flips. If the bit's value is unchanged, the toggle wire flips. The receiver never needs a separate request line. Per bit, the XOR of the two wires alternates 0, 1, 0, ... from word to word. A word is complete once every bit shows the parity the receiver expects next.

The encoder (`ledr_tx`) has two states. In `TX_OPEN` it accepts a strobe and applies the one-wire-per-bit update. It then moves to `TX_HOLD`, where `ready` is low for one cycle, and returns to `TX_OPEN`. The decoder (`ledr_rx`) also has two states. In `RX_WATCH` it waits until every bit reaches the expected parity. It then captures the value wires, inverts the expected parity and moves to `RX_SHOW`. It raises `valid` for that one cycle and returns to `RX_WATCH`. The model is fully synchronous to one clock, and the width is a parameter.

Top module: `ledr_link`

## Requirements
- R1: While and after reset, all value and toggle wires are 0, `ready` is 1, `valid` is 0, `word_out` is 0, and the decoder expects parity 1 for the first word.
- R2: On an accepted strobe (`send` high while `ready` is high, sampled at a rising edge), each bit changes exactly one of its two wires at that edge.
- R3: A bit whose new value differs from its value wire flips its value wire and keeps its toggle wire.
- R4: A bit whose new value equals its value wire flips its toggle wire and keeps its value wire. Sending the same word repeatedly therefore changes only toggle wires.
- R5: After an accepted strobe, the value wires equal the word that was sent.
- R6: `ready` is low for exactly the one cycle that follows each accepted strobe (state `TX_HOLD`), and is high otherwise.
- R7: A strobe seen while `ready` is low is ignored, and no wire changes at that edge.
- R8: The decoder raises `valid` for exactly one cycle. This starts at the edge after the wires change. During that cycle `word_out` equals the word that was sent.
- R9: A strobe given in the same cycle in which `valid` reports the previous word is accepted, and that word is delivered with its own `valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| send | input | 1 | Strobe that offers `word_in` |
| word_in | input | WIDTH | Word to transmit |
| ready | output | 1 | Encoder can accept a strobe |
| lane_data | output | WIDTH | Value wire of each bit |
| lane_phase | output | WIDTH | Toggle wire of each bit |
| word_out | output | WIDTH | Word captured by the decoder |
| valid | output | 1 | One-cycle pulse when `word_out` is new |

## Verification
Two functions can fall in the same cycle. The encoder can accept a fresh strobe while the decoder is still showing `valid` for the previous word. The bench provokes this by raising `send` in the very cycle that `valid` is high. It then checks two things: the old word is still shown correctly in that cycle, and the new word reaches the wires at the next edge, followed one edge later by a second `valid` pulse with the new value. The bench also holds `send` high through the `TX_HOLD` cycle with a different word, and checks that no wire moves at that edge.

// File: rtl/ledr_pkg.sv
package ledr_pkg;
    typedef enum logic {
        TX_OPEN = 1'b0,
        TX_HOLD = 1'b1
    } tx_state_t;

    typedef enum logic {
        RX_WATCH = 1'b0,
        RX_SHOW  = 1'b1
    } rx_state_t;
endpackage

// File: rtl/ledr_parity.sv
module ledr_parity #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [WIDTH-1:0] phase_in,
    input  logic             expect_par,
    output logic             all_at
);
    logic [WIDTH-1:0] hit;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign hit[i] = ((data_in[i] ^ phase_in[i]) == expect_par);
    end

    assign all_at = &hit;
endmodule

// File: rtl/ledr_tx.sv
module ledr_tx
    import ledr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send,
    input  logic [WIDTH-1:0] word_in,
    output logic             ready,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] phase_q
);
    tx_state_t state, state_nx;
    logic      take;

    assign take = send && (state == TX_OPEN);

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_OPEN: if (send) state_nx = TX_HOLD;
            TX_HOLD: state_nx = TX_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_OPEN;
        else        state <= state_nx;
    end

    always_comb begin
        ready = 1'b0;
        unique case (state)
            TX_OPEN: ready = 1'b1;
            TX_HOLD: ready = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            phase_q <= '0;
        end else if (take) begin
            data_q  <= word_in;
            phase_q <= phase_q ^ ~(word_in ^ data_q);
        end
    end

    assert_one_wire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (send && ready) |=> (((data_q ^ $past(data_q)) ^ (phase_q ^ $past(phase_q))) == '1));

    assert_value_wire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (send && ready) |=> (data_q == $past(word_in)));

    assert_hold_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (send && ready) |=> !ready);

    assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> ($stable(data_q) && $stable(phase_q)));
endmodule

// File: rtl/ledr_rx.sv
module ledr_rx
    import ledr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] data_in,
    input  logic [WIDTH-1:0] phase_in,
    output logic [WIDTH-1:0] word_q,
    output logic             valid
);
    rx_state_t state, state_nx;
    logic      expect_q;
    logic      all_at;

    ledr_parity #(.WIDTH(WIDTH)) u_parity (
        .data_in   (data_in),
        .phase_in  (phase_in),
        .expect_par(expect_q),
        .all_at    (all_at)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_WATCH: if (all_at) state_nx = RX_SHOW;
            RX_SHOW:  state_nx = RX_WATCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_WATCH;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_q <= 1'b1;
            word_q   <= '0;
        end else if (state == RX_WATCH && all_at) begin
            expect_q <= ~expect_q;
            word_q   <= data_in;
        end
    end

    always_comb begin
        valid = 1'b0;
        unique case (state)
            RX_WATCH: valid = 1'b0;
            RX_SHOW:  valid = 1'b1;
        endcase
    end

    assert_pulse_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_word_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (word_q == data_in));

    assert_parity_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> ((data_in ^ phase_in) == {WIDTH{~expect_q}}));
endmodule

// File: rtl/ledr_link.sv
module ledr_link #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             send,
    input  logic [WIDTH-1:0] word_in,
    output logic             ready,
    output logic [WIDTH-1:0] lane_data,
    output logic [WIDTH-1:0] lane_phase,
    output logic [WIDTH-1:0] word_out,
    output logic             valid
);
    ledr_tx #(.WIDTH(WIDTH)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .send   (send),
        .word_in(word_in),
        .ready  (ready),
        .data_q (lane_data),
        .phase_q(lane_phase)
    );

    ledr_rx #(.WIDTH(WIDTH)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_in (lane_data),
        .phase_in(lane_phase),
        .word_q  (word_out),
        .valid   (valid)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (lane_data == '0 && lane_phase == '0 && ready && !valid));
endmodule

// File: tb/ledr_link_bench.sv
module ledr_link_bench;
    localparam int W = 8;
    localparam int N = 8;
    localparam logic [W-1:0] WORDS [N] = '{8'h00, 8'h00, 8'hA5, 8'hA5,
                                           8'h5A, 8'hFF, 8'hFF, 8'h3C};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         send = 1'b0;
    logic [W-1:0] word_in = '0;
    logic         ready;
    logic [W-1:0] lane_data, lane_phase, word_out;
    logic         valid;
    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ledr_link #(.WIDTH(W)) u_ledr_link (
        .clk(clk), .rst_n(rst_n), .send(send), .word_in(word_in),
        .ready(ready), .lane_data(lane_data), .lane_phase(lane_phase),
        .word_out(word_out), .valid(valid)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_reset(input string tag);
        chk(lane_data == '0, {tag, " R1 data"}, 32'(lane_data), 0);
        chk(lane_phase == '0, {tag, " R1 phase"}, 32'(lane_phase), 0);
        chk(ready == 1'b1, {tag, " R1 ready"}, 32'(ready), 1);
        chk(valid == 1'b0, {tag, " R1 valid"}, 32'(valid), 0);
        chk(word_out == '0, {tag, " R1 word_out"}, 32'(word_out), 0);
    endtask

    task automatic send_word(input logic [W-1:0] w);
        logic [W-1:0] pd, pp, td, tp;
        pd = lane_data;
        pp = lane_phase;
        send = 1'b1;
        word_in = w;
        step();
        word_in = ~w;
        td = lane_data ^ pd;
        tp = lane_phase ^ pp;
        chk(lane_data == w, "R5 value wires", 32'(lane_data), 32'(w));
        chk(((td ^ tp) == '1) && ((td & tp) == '0), "R2 one wire per bit", 32'({td, tp}), 32'({w ^ pd, ~(w ^ pd)}));
        chk(td == (w ^ pd), "R3 value wire flips", 32'(td), 32'(w ^ pd));
        chk(tp == ~(w ^ pd), "R4 toggle wire flips", 32'(tp), 32'(~(w ^ pd)));
        chk(ready == 1'b0, "R6 ready low", 32'(ready), 0);
        chk(valid == 1'b0, "R8 no early valid", 32'(valid), 0);
        step();
        send = 1'b0;
        chk(lane_data == w && lane_phase == (pp ^ tp), "R7 busy strobe ignored", 32'({lane_data, lane_phase}), 32'({w, pp ^ tp}));
        chk(ready == 1'b1, "R6 ready back", 32'(ready), 1);
        chk(valid == 1'b1, "R8 valid", 32'(valid), 1);
        chk(word_out == w, "R8 word_out", 32'(word_out), 32'(w));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [W-1:0] p0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_reset("initial");
        rst_n = 1'b1;
        step();
        check_reset("idle");

        for (int k = 0; k < N; k++) begin
            send_word(WORDS[k]);
            step();
            chk(valid == 1'b0, "R8 single pulse", 32'(valid), 0);
        end

        // R4: three identical words change only toggle wires
        p0 = lane_phase;
        for (int k = 0; k < 3; k++) begin
            send_word(8'h3C);
            step();
        end
        chk(lane_data == 8'h3C && lane_phase == ~p0, "R4 repeat toggles phase only", 32'({lane_data, lane_phase}), 32'({8'h3C, ~p0}));

        // R9: strobe in the cycle valid is high
        send_word(8'h81);
        send = 1'b1;
        word_in = 8'h7E;
        chk(valid == 1'b1 && word_out == 8'h81, "R9 old word shown", 32'(word_out), 32'h81);
        step();
        send = 1'b0;
        chk(lane_data == 8'h7E, "R9 new word accepted", 32'(lane_data), 32'h7E);
        chk(valid == 1'b0 && ready == 1'b0, "R9 pulse ends", 32'({valid, ready}), 0);
        step();
        chk(valid == 1'b1 && word_out == 8'h7E, "R9 second valid", 32'(word_out), 32'h7E);
        step();

        // R1: reset again mid-run, parity expectation restarts
        rst_n = 1'b0;
        step();
        check_reset("mid-run");
        rst_n = 1'b1;
        step();
        send_word(8'h00);
        chk(lane_phase == 8'hFF, "R1 parity restarts", 32'(lane_phase), 32'hFF);
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule